// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit carries out a single load or store micro-operation for a 32-bit register-based core. The issuing stage supplies a base register value, a signed immediate offset, an offset-mode code, a data-type code and the store data. The unit works out the access address and drives a synchronous single-port memory with per-byte enables. Loaded data comes back zero-extended or sign-extended to the full register width. The unit also reports the updated base register value and a write strobe for it. A doubleword transfer runs as two word beats at consecutive word addresses.

A request is taken in any cycle in which `busy` is low. The memory is driven from registered state, and its read data is expected one cycle after `mem_en`. The result is presented for exactly one cycle while `done` is high. Misaligned or illegal requests complete without touching memory and without updating the base register. The caller decodes the instruction, evaluates its condition, and owns the register file.

Top module: `ldst_unit`

## Requirements
- R1: With offset mode 0 (plain), the access address is base plus the sign-extended offset, and `base_we` stays low at completion.
- R2: With offset mode 1 (pre-index), the access address is base plus offset, and at completion `base_we` is high with `base_val` equal to base plus offset.
- R3: With offset mode 2 (post-index), the access address is the unmodified base, and at completion `base_we` is high with `base_val` equal to base plus offset.
- R4: Type 1 (unsigned byte) loads take the byte in lane `addr[1:0]` and zero bits 31:8. Type 3 (unsigned halfword) loads take the halfword selected by `addr[1]` and zero bits 31:16.
- R5: Type 2 (signed byte) loads copy bit 7 of the selected byte into bits 31:8. Type 4 (signed halfword) loads copy bit 15 of the selected halfword into bits 31:16.
- R6: Type 0 (word) moves all 32 bits unchanged in one beat with `mem_be` = 4'b1111.
- R7: Type 5 (doubleword) makes two beats, at address A and then at A+4. On loads, `rd0` returns the word at A and `rd1` the word at A+4. On stores, `req_wdata0` is written at A and `req_wdata1` at A+4.
- R8: Byte and halfword stores use little-endian lanes. A byte store sets only `mem_be[addr[1:0]]`. A halfword store sets 4'b0011 when `addr[1]` is 0 and 4'b1100 when it is 1. In both cases the data is replicated so that it appears in the enabled lanes.
- R9: A store with a signed type (2 or 4), type code 6 or 7, or offset mode 3 completes with `fault_illegal` high, with no memory access and `base_we` low.
- R10: On an otherwise legal request, a halfword access with address bit 0 set, or a word or doubleword access with `addr[1:0]` nonzero, completes with `fault_align` high, with no memory access and `base_we` low.
- R11: `busy` is high from the cycle after acceptance through the last memory beat. `done` rises in the cycle after the last beat (or in the cycle after acceptance for a faulting request). A `req_valid` presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Offset mode: 0 plain, 1 pre-index, 2 post-index, 3 reserved |
| req_type | input | 3 | Data type: 0 word, 1 ubyte, 2 sbyte, 3 uhalf, 4 shalf, 5 doubleword |
| req_base | input | DW | Base register value |
| req_off | input | OFFW | Signed immediate offset |
| req_wdata0 | input | DW | Store data (first register) |
| req_wdata1 | input | DW | Store data for the second doubleword beat |
| busy | output | 1 | Memory beats in progress |
| done | output | 1 | One-cycle completion strobe; results valid |
| fault_align | output | 1 | Misaligned access, valid with `done` |
| fault_illegal | output | 1 | Illegal type/mode combination, valid with `done` |
| rd0 | output | DW | Extended load result / first doubleword word |
| rd1 | output | DW | Second doubleword word |
| base_we | output | 1 | Base register writeback strobe |
| base_val | output | DW | Base writeback value |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | DW | Byte address |
| mem_be | output | DW/8 | Byte enables |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after `mem_en` |

## Verification
The bench builds the unit with a 6-bit offset and signed loads enabled. That offset width lets a sweep reach every negative and positive offset region, every low-address residue and every offset mode. The bench crosses all eight type codes, both directions and all four mode codes against four bases with differing low bits. Its small 16-word memory model wraps addresses, so doubleword pairs, lane placement and sign bits are all observed. A separate case issues a second request during a doubleword beat to show that it is ignored.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      AM_PLAIN = 2'd0,
      AM_PRE   = 2'd1,
      AM_POST  = 2'd2,
      AM_RSVD  = 2'd3
   } amode_e;

   typedef enum logic [2:0] {
      DT_WORD  = 3'd0,
      DT_UBYTE = 3'd1,
      DT_SBYTE = 3'd2,
      DT_UHALF = 3'd3,
      DT_SHALF = 3'd4,
      DT_DWORD = 3'd5,
      DT_RSV6  = 3'd6,
      DT_RSV7  = 3'd7
   } dtype_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT0 = 2'd1,
      ST_BEAT1 = 2'd2,
      ST_FIN   = 2'd3
   } lsq_state_e;

   function automatic logic is_signed_type(input dtype_e t);
      return (t == DT_SBYTE) || (t == DT_SHALF);
   endfunction

   function automatic logic is_half_type(input dtype_e t);
      return (t == DT_UHALF) || (t == DT_SHALF);
   endfunction

   function automatic logic is_byte_type(input dtype_e t);
      return (t == DT_UBYTE) || (t == DT_SBYTE);
   endfunction

endpackage

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_pkg::*;
#(
   parameter int DW         = 32,
   parameter int OFFW       = 12,
   parameter bit SIGN_LOADS = 1'b1
) (
   input  logic [DW-1:0]   base,
   input  logic [OFFW-1:0] off,
   input  logic [1:0]      mode,
   input  logic [2:0]      dtype,
   input  logic            store,
   output logic [DW-1:0]   acc_addr,
   output logic [DW-1:0]   wb_addr,
   output logic            writes_base,
   output logic            illegal,
   output logic            misalign
);

   localparam int EXTW = DW - OFFW;

   logic [DW-1:0] off_x;
   logic [DW-1:0] sum;
   amode_e        am;
   dtype_e        dt;

   assign am    = amode_e'(mode);
   assign dt    = dtype_e'(dtype);
   assign off_x = {{EXTW{off[OFFW-1]}}, off};
   assign sum   = base + off_x;

   always_comb begin
      acc_addr    = (am == AM_POST) ? base : sum;
      wb_addr     = sum;
      writes_base = (am == AM_PRE) || (am == AM_POST);
   end

   logic bad_type;
   logic bad_sign;

   generate
      if (SIGN_LOADS) begin : g_sign_ok
         assign bad_sign = store && is_signed_type(dt);
      end else begin : g_sign_off
         assign bad_sign = is_signed_type(dt);
      end
   endgenerate

   assign bad_type = (dt == DT_RSV6) || (dt == DT_RSV7);
   assign illegal  = bad_type || bad_sign || (am == AM_RSVD);

   always_comb begin
      misalign = 1'b0;
      if (is_half_type(dt))
         misalign = acc_addr[0];
      else if ((dt == DT_WORD) || (dt == DT_DWORD))
         misalign = (acc_addr[1:0] != 2'b00);
   end

endmodule

// File: rtl/ldst_lane.sv
module ldst_lane
   import ldst_pkg::*;
#(
   parameter int DW         = 32,
   parameter bit SIGN_LOADS = 1'b1
) (
   input  logic [2:0]        dtype,
   input  logic [1:0]        lo,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     rdata,
   output logic [DW-1:0]     st_data,
   output logic [DW/8-1:0]   st_be,
   output logic [DW-1:0]     ld_data
);

   localparam int BYTES = DW / 8;
   localparam int HALFS = BYTES / 2;

   dtype_e dt;
   assign dt = dtype_e'(dtype);

   // Store lane placement: replicate, then enable only the addressed lanes.
   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_lane
         always_comb begin
            if (is_byte_type(dt)) begin
               st_data[g*8 +: 8] = wdata[7:0];
               st_be[g]          = (lo == 2'(g));
            end else if (is_half_type(dt)) begin
               st_data[g*8 +: 8] = wdata[(g%2)*8 +: 8];
               st_be[g]          = (lo[1] == 1'(g / 2));
            end else begin
               st_data[g*8 +: 8] = wdata[g*8 +: 8];
               st_be[g]          = 1'b1;
            end
         end
      end
   endgenerate

   // Load lane extraction.
   logic [7:0]  sel_b;
   logic [15:0] sel_h;

   always_comb begin
      sel_b = rdata[{lo, 3'b000} +: 8];
      sel_h = rdata[{lo[1], 4'b0000} +: 16];
   end

   logic [DW-1:0] ext_sb;
   logic [DW-1:0] ext_sh;

   generate
      if (SIGN_LOADS) begin : g_sext
         assign ext_sb = {{(DW-8){sel_b[7]}}, sel_b};
         assign ext_sh = {{(DW-16){sel_h[15]}}, sel_h};
      end else begin : g_zext
         assign ext_sb = {{(DW-8){1'b0}}, sel_b};
         assign ext_sh = {{(DW-16){1'b0}}, sel_h};
      end
   endgenerate

   always_comb begin
      unique case (dt)
         DT_UBYTE: ld_data = {{(DW-8){1'b0}}, sel_b};
         DT_SBYTE: ld_data = ext_sb;
         DT_UHALF: ld_data = {{(DW-16){1'b0}}, sel_h};
         DT_SHALF: ld_data = ext_sh;
         default:  ld_data = rdata;
      endcase
   end

   always_comb begin
      if (dt == DT_UBYTE)
         assert_byte_one_lane_R8: assert ($countones(st_be) == 1);
      if (dt == DT_UHALF)
         assert_half_two_lanes_R8: assert ($countones(st_be) == 2);
      if (dt == DT_UBYTE)
         assert_ubyte_zero_R4: assert (ld_data[DW-1:8] == '0);
   end

   if (HALFS < 1) begin : g_bad_half
      $error("ldst_lane: data width too small for halfword lanes");
   end

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
   import ldst_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_store,
   input  logic [2:0]      req_type,
   input  logic [DW-1:0]   acc_in,
   input  logic [DW-1:0]   wb_in,
   input  logic            wb_en_in,
   input  logic            illegal_in,
   input  logic            misalign_in,
   input  logic [DW-1:0]   req_wdata0,
   input  logic [DW-1:0]   req_wdata1,
   input  logic [DW-1:0]   mem_rdata,
   input  logic [DW-1:0]   ld_data,
   output logic            busy,
   output logic            done,
   output logic            mem_en,
   output logic            mem_we,
   output logic [DW-1:0]   mem_addr,
   output logic [DW-1:0]   beat_wdata,
   output logic [2:0]      dtype_q,
   output logic [1:0]      lo_q,
   output logic            fault_align,
   output logic            fault_illegal,
   output logic            base_we,
   output logic [DW-1:0]   base_val,
   output logic [DW-1:0]   rd0,
   output logic [DW-1:0]   rd1
);

   localparam int BYTES = DW / 8;

   lsq_state_e    state, state_n;
   logic          store_q, wb_q, ill_q, mis_q;
   logic [DW-1:0] acc_q, wb_addr_q, wd0_q, wd1_q, first_q;
   logic          accept, fault_in, fault_q, dword_q;

   assign accept   = req_valid && !busy;
   assign fault_in = illegal_in || misalign_in;
   assign fault_q  = ill_q || mis_q;
   assign dword_q  = (dtype_e'(dtype_q) == DT_DWORD);

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE, ST_FIN: begin
            if (accept) state_n = fault_in ? ST_FIN : ST_BEAT0;
            else        state_n = ST_IDLE;
         end
         ST_BEAT0: state_n = dword_q ? ST_BEAT1 : ST_FIN;
         ST_BEAT1: state_n = ST_FIN;
         default:  state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         store_q   <= 1'b0;
         wb_q      <= 1'b0;
         ill_q     <= 1'b0;
         mis_q     <= 1'b0;
         dtype_q   <= 3'd0;
         acc_q     <= '0;
         wb_addr_q <= '0;
         wd0_q     <= '0;
         wd1_q     <= '0;
         first_q   <= '0;
      end else begin
         state <= state_n;
         if (accept) begin
            store_q   <= req_store;
            wb_q      <= wb_en_in;
            ill_q     <= illegal_in;
            mis_q     <= misalign_in && !illegal_in;
            dtype_q   <= req_type;
            acc_q     <= acc_in;
            wb_addr_q <= wb_in;
            wd0_q     <= req_wdata0;
            wd1_q     <= req_wdata1;
         end
         if (state == ST_BEAT1)
            first_q <= mem_rdata;
      end
   end

   assign lo_q = acc_q[1:0];

   always_comb begin
      busy       = (state == ST_BEAT0) || (state == ST_BEAT1);
      done       = (state == ST_FIN);
      mem_en     = busy;
      mem_we     = busy && store_q;
      mem_addr   = (state == ST_BEAT1) ? acc_q + DW'(BYTES) : acc_q;
      beat_wdata = (state == ST_BEAT1) ? wd1_q : wd0_q;
   end

   always_comb begin
      fault_align   = done && mis_q;
      fault_illegal = done && ill_q;
      base_we       = done && wb_q && !fault_q;
      base_val      = wb_addr_q;
      rd0           = '0;
      rd1           = '0;
      if (done && !store_q && !fault_q) begin
         rd0 = dword_q ? first_q : ld_data;
         rd1 = dword_q ? mem_rdata : '0;
      end
   end

   assert_beat1_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BEAT1) |-> ($past(state) == ST_BEAT0) && dword_q);

   assert_beat1_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BEAT1) |-> (mem_addr == $past(mem_addr) + DW'(BYTES)));

   assert_fault_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_q) |-> !$past(mem_en));

   assert_busy_then_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dword_q) |=> done);

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit #(
   parameter int DW         = 32,
   parameter int OFFW       = 12,
   parameter bit SIGN_LOADS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_mode,
   input  logic [2:0]        req_type,
   input  logic [DW-1:0]     req_base,
   input  logic [OFFW-1:0]   req_off,
   input  logic [DW-1:0]     req_wdata0,
   input  logic [DW-1:0]     req_wdata1,
   output logic              busy,
   output logic              done,
   output logic              fault_align,
   output logic              fault_illegal,
   output logic [DW-1:0]     rd0,
   output logic [DW-1:0]     rd1,
   output logic              base_we,
   output logic [DW-1:0]     base_val,
   output logic              mem_en,
   output logic              mem_we,
   output logic [DW-1:0]     mem_addr,
   output logic [DW/8-1:0]   mem_be,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata
);

   if (DW != 32) begin : g_bad_dw
      $error("ldst_unit: DW must be 32");
   end
   if ((OFFW < 2) || (OFFW >= DW)) begin : g_bad_offw
      $error("ldst_unit: OFFW must lie in [2, DW-1]");
   end

   logic [DW-1:0] acc_c, wb_c, beat_wdata, ld_data;
   logic          wb_en_c, ill_c, mis_c;
   logic [2:0]    dtype_q;
   logic [1:0]    lo_q;

   ldst_agu #(.DW(DW), .OFFW(OFFW), .SIGN_LOADS(SIGN_LOADS)) u_agu (
      .base        (req_base),
      .off         (req_off),
      .mode        (req_mode),
      .dtype       (req_type),
      .store       (req_store),
      .acc_addr    (acc_c),
      .wb_addr     (wb_c),
      .writes_base (wb_en_c),
      .illegal     (ill_c),
      .misalign    (mis_c)
   );

   ldst_seq #(.DW(DW)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_store     (req_store),
      .req_type      (req_type),
      .acc_in        (acc_c),
      .wb_in         (wb_c),
      .wb_en_in      (wb_en_c),
      .illegal_in    (ill_c),
      .misalign_in   (mis_c),
      .req_wdata0    (req_wdata0),
      .req_wdata1    (req_wdata1),
      .mem_rdata     (mem_rdata),
      .ld_data       (ld_data),
      .busy          (busy),
      .done          (done),
      .mem_en        (mem_en),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .beat_wdata    (beat_wdata),
      .dtype_q       (dtype_q),
      .lo_q          (lo_q),
      .fault_align   (fault_align),
      .fault_illegal (fault_illegal),
      .base_we       (base_we),
      .base_val      (base_val),
      .rd0           (rd0),
      .rd1           (rd1)
   );

   ldst_lane #(.DW(DW), .SIGN_LOADS(SIGN_LOADS)) u_lane (
      .dtype   (dtype_q),
      .lo      (lo_q),
      .wdata   (beat_wdata),
      .rdata   (mem_rdata),
      .st_data (mem_wdata),
      .st_be   (mem_be),
      .ld_data (ld_data)
   );

   assert_no_wb_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (fault_align || fault_illegal)) |-> !base_we);

   assert_busy_from_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   assert_faults_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_align && fault_illegal));

   assert_we_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en && (mem_be != '0));

endmodule

// File: tb/sim_ldst_unit.sv
module sim_ldst_unit;

   localparam int DW   = 32;
   localparam int OFFW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_store = 1'b0;
   logic [1:0]      req_mode = '0;
   logic [2:0]      req_type = '0;
   logic [DW-1:0]   req_base = '0;
   logic [OFFW-1:0] req_off = '0;
   logic [DW-1:0]   req_wdata0 = '0;
   logic [DW-1:0]   req_wdata1 = '0;
   logic            busy, done, fault_align, fault_illegal, base_we;
   logic [DW-1:0]   rd0, rd1, base_val, mem_addr, mem_wdata;
   logic [DW-1:0]   mem_rdata = '0;
   logic            mem_en, mem_we;
   logic [3:0]      mem_be;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   ldst_unit #(.DW(DW), .OFFW(OFFW), .SIGN_LOADS(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_mode(req_mode), .req_type(req_type), .req_base(req_base),
      .req_off(req_off), .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
      .busy(busy), .done(done), .fault_align(fault_align),
      .fault_illegal(fault_illegal), .rd0(rd0), .rd1(rd1), .base_we(base_we),
      .base_val(base_val), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   logic [31:0] mem [16];

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[5:2]];
         end
      end
   end

   function automatic logic [31:0] pat(input int i);
      return 32'h8F3C_A571 ^ (32'(i) * 32'h1357_9BDF);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic run_op(input bit st, input int md, input int ty,
                         input logic [31:0] b, input int off,
                         input logic [31:0] w0, input logic [31:0] w1);
      logic [31:0] em [16];
      logic [31:0] a, acc, m0, m1, exp0, exp1, sel, got_addr [2];
      logic        ill, mis, wb;
      int          idx, nb, guard, exp_nb;
      bit          we_seen;
      string       rq;

      for (int i = 0; i < 16; i++) begin
         mem[i] = pat(i + off + md);
         em[i]  = mem[i];
      end
      a   = b + 32'(off);
      acc = (md == 2) ? b : a;
      idx = int'(acc[5:2]);
      m0  = em[idx];
      m1  = em[(idx + 1) % 16];
      ill = (md == 3) || (ty >= 6) || (st && (ty == 2 || ty == 4));
      mis = 1'b0;
      if (ty == 3 || ty == 4) mis = acc[0];
      if (ty == 0 || ty == 5) mis = (acc[1:0] != 0);
      mis = mis && !ill;
      wb  = (md == 1 || md == 2) && !ill && !mis;
      exp_nb = (ill || mis) ? 0 : ((ty == 5) ? 2 : 1);

      exp0 = 32'h0;
      exp1 = 32'h0;
      sel  = m0 >> (8 * acc[1:0]);
      case (ty)
         0: exp0 = m0;
         1: exp0 = {24'h0, sel[7:0]};
         2: exp0 = {{24{sel[7]}}, sel[7:0]};
         3: exp0 = {16'h0, m0[16*acc[1] +: 16]};
         4: exp0 = {{16{m0[16*acc[1]+15]}}, m0[16*acc[1] +: 16]};
         5: begin exp0 = m0; exp1 = m1; end
         default: exp0 = 32'h0;
      endcase
      if (st && exp_nb > 0) begin
         case (ty)
            1: em[idx][8*acc[1:0] +: 8] = w0[7:0];
            3: em[idx][16*acc[1] +: 16] = w0[15:0];
            5: begin em[idx] = w0; em[(idx + 1) % 16] = w1; end
            default: em[idx] = w0;
         endcase
      end

      case (md)
         0: rq = "R1";
         1: rq = "R2";
         2: rq = "R3";
         default: rq = "R9";
      endcase

      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_mode = 2'(md); req_type = 3'(ty);
      req_base = b; req_off = OFFW'(off); req_wdata0 = w0; req_wdata1 = w1;
      @(negedge clk);
      req_valid = 1'b0;
      nb = 0; guard = 0; we_seen = 1'b0;
      got_addr[0] = 'x; got_addr[1] = 'x;
      while (!done && guard < 8) begin
         if (mem_en) begin
            if (nb < 2) got_addr[nb] = mem_addr;
            if (mem_we) we_seen = 1'b1;
            nb++;
         end
         guard++;
         @(negedge clk);
      end

      check("R11 done reached", 32'(done), 32'h1);
      check("R11 beat count", 32'(nb), 32'(exp_nb));
      check("R9 illegal flag", 32'(fault_illegal), 32'(ill));
      check("R10 align flag", 32'(fault_align), 32'(mis));
      check({rq, " base_we"}, 32'(base_we), 32'(wb));
      if (wb) check({rq, " base_val"}, base_val, a);
      if (exp_nb > 0) begin
         check({rq, " access address"}, got_addr[0], acc);
         check("R8 write strobe matches direction", 32'(we_seen), 32'(st));
      end
      if (exp_nb == 2) check("R7 second beat address", got_addr[1], acc + 32'd4);
      if (exp_nb > 0 && !st) begin
         case (ty)
            1, 3: check("R4 zero-extended load", rd0, exp0);
            2, 4: check("R5 sign-extended load", rd0, exp0);
            5: begin
               check("R7 first word", rd0, exp0);
               check("R7 second word", rd1, exp1);
            end
            default: check("R6 word load", rd0, exp0);
         endcase
      end
      begin
         int diff = 0;
         for (int i = 0; i < 16; i++) if (mem[i] !== em[i]) diff++;
         if (st) check(ty == 5 ? "R7 store image" : (ty == 0 ? "R6 store image" :
                       (exp_nb == 0 ? "R9/R10 no write" : "R8 store lanes")),
                       32'(diff), 32'h0);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset busy", 32'(busy), 32'h0);
      check("R11 reset done", 32'(done), 32'h0);
      check("R11 reset mem_en", 32'(mem_en), 32'h0);
      check("R1 reset base_we", 32'(base_we), 32'h0);

      for (int st = 0; st < 2; st++)
         for (int md = 0; md < 4; md++)
            for (int ty = 0; ty < 8; ty++)
               for (int bi = 0; bi < 4; bi++)
                  foreach (offs[k])
                     run_op(st[0], md, ty, 32'd64 + 32'(bi), offs[k],
                            32'hC1D2_E3F4 ^ 32'(k * 7 + bi),
                            32'h1A2B_3C4D + 32'(k));

      // R11: a request presented while busy is ignored.
      for (int i = 0; i < 16; i++) mem[i] = pat(i);
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_mode = 2'd0; req_type = 3'd5;
      req_base = 32'd64; req_off = '0;
      @(negedge clk);
      req_store = 1'b1; req_type = 3'd0; req_base = 32'd80;
      check("R11 busy on first beat", 32'(busy), 32'h1);
      @(negedge clk);
      check("R11 ignored request: beat address", mem_addr, 32'd68);
      check("R11 ignored request: no write", 32'(mem_we), 32'h0);
      req_valid = 1'b0;
      @(negedge clk);
      check("R11 done after doubleword", 32'(done), 32'h1);
      check("R7 second word after ignored request", rd1, pat(1));
      check("R11 ignored store left memory", mem[4], pat(4));
      @(negedge clk);
      check("R11 idle after completion", 32'(done | busy), 32'h0);

      finish_run();
   end

   int offs [9] = '{-8, -5, -2, 0, 1, 3, 6, 8, 30};

endmodule